// File: doc/BRIEF.md
# Multi-Core Launch and Inter-Processor Interrupt Controller

This block owns the run/halt state of a cluster of processor cores. When reset is released, only core 0 is allowed to run and every other core is held parked. Software on a running core, or host logic, wakes the others by posting an inter-processor interrupt (IPI) that names a target core index. Each core sees two flags from the block: a halted flag that keeps it from issuing instructions, and an interrupt-pending flag.

A core clears its pending flag with a per-core acknowledge. A parked core is released by a per-core wake pulse, and that pulse only takes effect when the core already has an IPI pending. A global stop input parks every core at once. Address decoding of the IPI region, the cores themselves and the bus all sit outside this block. The block delivers a target index and a request strobe, and it returns the two flag vectors.

Top module: `core_launch_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `halted[0]` is 0 and `halted[i]` is 1 for every core index i from 1 to NUM_CORES-1.
- R2: While reset is asserted, every bit of `pending` is 0.
- R3: When `ipi_req` is high at a clock edge and `ipi_target` holds a value t less than NUM_CORES, bit t of `pending` is 1 after that edge. No other bit of `pending` is set by that request.
- R4: When `ipi_req` is high and `ipi_target` is NUM_CORES or greater, the request changes neither `pending` nor `halted`.
- R5: When `stop_all` is high at a clock edge, every bit of `halted` is 1 after that edge.
- R6: When `wake[i]` is high at an edge, core i is halted, core i has its pending bit set, and `stop_all` is low, then `halted[i]` is 0 after that edge.
- R7: A `wake[i]` pulse while `pending[i]` is 0 leaves `halted[i]` unchanged.
- R8: When `pend_ack[i]` is high at an edge, `pending[i]` is 0 after that edge, unless an IPI targeting core i arrives at the same edge. In that case `pending[i]` is 1.
- R9: When `stop_all` and an otherwise valid `wake[i]` arrive at the same edge, `halted[i]` is 1 after that edge.
- R10: The halted and pending flags change only at a clock edge, and by no rule other than R3 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ipi_req | input | 1 | IPI request strobe, one request per cycle |
| ipi_target | input | $clog2(NUM_CORES+1) | Target core index of the IPI |
| stop_all | input | 1 | Global stop, parks every core |
| wake | input | NUM_CORES | Per-core wake pulse |
| pend_ack | input | NUM_CORES | Per-core acknowledge of the pending IPI |
| halted | output | NUM_CORES | Per-core halted flag |
| pending | output | NUM_CORES | Per-core interrupt-pending flag |

## Verification
The bench builds the block with NUM_CORES set to 5. This is not a power of two, so the 3-bit target index can carry the values 5, 6 and 7, and the out-of-range rejection is exercised on real encodings rather than on a value that cannot occur. Five cores also leave enough parked secondaries to pit stop against wake, and ack against IPI, on different cores within one run. A long random phase, with wake and ack fired densely, then mixes all of these collisions.

// File: rtl/core_launch_ctrl.sv
module core_launch_ctrl #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = $clog2(NUM_CORES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ipi_req,
  input  logic [IDX_W-1:0]     ipi_target,
  input  logic                 stop_all,
  input  logic [NUM_CORES-1:0] wake,
  input  logic [NUM_CORES-1:0] pend_ack,
  output logic [NUM_CORES-1:0] halted,
  output logic [NUM_CORES-1:0] pending
);

  localparam logic [NUM_CORES-1:0] PARK_AT_BOOT = ~NUM_CORES'(1);
  localparam logic [IDX_W-1:0]     CORE_LIMIT   = IDX_W'(NUM_CORES);

  logic                 tgt_ok;
  logic [NUM_CORES-1:0] ipi_hit;
  logic [NUM_CORES-1:0] wake_ok;
  logic [NUM_CORES-1:0] pend_nxt;
  logic [NUM_CORES-1:0] halt_nxt;

  assign tgt_ok   = ipi_req && (ipi_target < CORE_LIMIT);
  assign ipi_hit  = tgt_ok ? (NUM_CORES'(1) << ipi_target) : '0;
  assign wake_ok  = wake & halted & pending;
  assign pend_nxt = ipi_hit | (pending & ~pend_ack);
  assign halt_nxt = stop_all ? '1 : (halted & ~wake_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted  <= PARK_AT_BOOT;
      pending <= '0;
    end else begin
      halted  <= halt_nxt;
      pending <= pend_nxt;
    end
  end

  a_r4_bad_target_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_req && ipi_target >= CORE_LIMIT && pend_ack == '0 && !stop_all && wake == '0)
      |=> ($stable(pending) && $stable(halted)));

  a_r5_stop_parks_all: assert property (@(posedge clk) disable iff (!rst_n)
    stop_all |=> (&halted));

  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_req && pend_ack == '0) |=> ($countones(pending & ~$past(pending)) <= 1));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    localparam logic [IDX_W-1:0] ME = IDX_W'(c);

    a_r3_ipi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_req && ipi_target == ME) |=> pending[c]);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_ack[c] && !(ipi_req && ipi_target == ME)) |=> !pending[c]);

    a_r6_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_all && wake[c] && halted[c] && pending[c]) |=> !halted[c]);

    a_r7_wake_needs_ipi: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_all && wake[c] && !pending[c]) |=> $stable(halted[c]));

    a_r9_stop_beats_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_all && wake[c]) |=> halted[c]);

    a_r10_no_spurious_run: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted[c]) |-> $past(wake[c] && pending[c]));
  end

endmodule

// File: tb/core_launch_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_launch_ctrl_tb_top;
  localparam int N = 5;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ipi_req = 1'b0;
  logic [IW-1:0] ipi_target = '0;
  logic stop_all = 1'b0;
  logic [N-1:0] wake = '0;
  logic [N-1:0] pend_ack = '0;
  logic [N-1:0] halted;
  logic [N-1:0] pending;

  int compared = 0;
  int mismatched = 0;
  bit m_halt[N];
  bit m_pend[N];

  always #2.5 clk = ~clk;

  core_launch_ctrl #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ipi_req(ipi_req), .ipi_target(ipi_target),
    .stop_all(stop_all), .wake(wake), .pend_ack(pend_ack),
    .halted(halted), .pending(pending));

  task automatic compare_all(input string tag_h, input string tag_p);
    for (int c = 0; c < N; c++) begin
      compared++;
      if (halted[c] !== m_halt[c]) begin
        mismatched++;
        $display("FAIL %s halted[%0d] actual=%b expected=%b", tag_h, c, halted[c], m_halt[c]);
      end
      compared++;
      if (pending[c] !== m_pend[c]) begin
        mismatched++;
        $display("FAIL %s pending[%0d] actual=%b expected=%b", tag_p, c, pending[c], m_pend[c]);
      end
    end
  endtask

  task automatic step(input bit rq, input int tgt, input bit st,
                      input logic [N-1:0] wk, input logic [N-1:0] ak, input string tag);
    bit nh[N];
    bit np[N];
    ipi_req = rq; ipi_target = IW'(tgt); stop_all = st; wake = wk; pend_ack = ak;
    for (int c = 0; c < N; c++) begin
      if (rq && tgt == c) np[c] = 1'b1;
      else if (ak[c]) np[c] = 1'b0;
      else np[c] = m_pend[c];
      if (st) nh[c] = 1'b1;
      else if (wk[c] && m_halt[c] && m_pend[c]) nh[c] = 1'b0;
      else nh[c] = m_halt[c];
    end
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      m_halt[c] = nh[c];
      m_pend[c] = np[c];
    end
    @(negedge clk);
    compare_all(tag, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      m_halt[c] = (c != 0);
      m_pend[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    compare_all("R1", "R2");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1", "R2");

    step(1, 2, 0, '0, '0, "R3");
    step(1, 3, 0, 5'b01000, '0, "R7");
    step(0, 0, 0, 5'b00100, '0, "R6");
    step(0, 0, 0, 5'b10000, '0, "R7");
    step(1, 5, 0, '0, '0, "R4");
    step(1, 7, 0, '0, '0, "R4");
    step(1, 6, 0, 5'b11111, '0, "R4");
    step(0, 0, 0, '0, 5'b00100, "R8");
    step(1, 1, 0, '0, 5'b00010, "R8");
    step(1, 4, 0, '0, 5'b00010, "R8");
    step(0, 0, 1, 5'b10000, '0, "R9");
    step(0, 0, 1, '0, '0, "R5");
    step(0, 0, 0, 5'b10000, '0, "R6");
    step(1, 0, 0, '0, '0, "R3");
    step(0, 0, 0, 5'b00001, 5'b00001, "R6");
    step(0, 0, 0, '0, '0, "R10");

    for (int k = 0; k < 400; k++) begin
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           ($urandom_range(0, 15) == 0), N'($urandom), N'($urandom & $urandom), "R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule